// File: doc/BRIEF.md
# Edge Change Interrupt Controller

This block watches a bank of digital inputs (24 by default) and raises an interrupt when one of them changes in a direction that software has asked to hear about. Each channel has its own rising-edge and falling-edge enable bit. The two enable masks are loaded one byte at a time. A control register has two global polarity gates, two source enables and a master enable.

Any enabled change sets a sticky edge flag. A second enabled change that arrives while the edge flag is still set also sets an overflow flag. Software reads a status byte that holds both flags and the master interrupt bit, and acknowledges events by writing ones to a clear register. The inputs are taken to be synchronous to `clk` already. Register reads are combinational from `rd_addr`. Writes take effect at the clock edge where `wr_en` is high.

Top module: `edge_event_irq`

## Requirements
- R1: After reset the rising mask, the falling mask, the control register and both flags are zero, and `irq` is low.
- R2: Rising-mask byte k (channels 8k to 8k+7) is written and read at offset k. Falling-mask byte k is at offset 4+k. Reads return the values written.
- R3: A channel that goes from 0 to 1 while its rising-mask bit and control bit 3 are set sets the edge flag (status bit 0). The flag is set at the first clock edge that samples the new input value.
- R4: A channel that goes from 1 to 0 while its falling-mask bit and control bit 4 are set sets the edge flag at the first clock edge that samples the new input value.
- R5: A change on a channel whose mask bit for that direction is clear, or whose polarity gate (control bit 3 or 4) is clear, leaves both flags unchanged.
- R6: An enabled change that arrives while the edge flag is already set also sets the overflow flag (status bit 1). Once set, both flags stay set until they are cleared.
- R7: Writing the clear register at offset 10 with bit 3 set clears the edge flag, and with bit 2 set clears the overflow flag. The other bits of that write have no effect.
- R8: When an enabled change and a clear write fall in the same cycle, the edge flag is set after that edge.
- R9: Status bit 2 and `irq` are both high exactly when control bit 2 (master) is set and either the edge flag is set with control bit 0, or the overflow flag is set with control bit 1.
- R10: The control register at offset 8 keeps its low 5 bits and reads bits 7:5 as zero. Status is read at offset 9, with bits 7:3 zero. Writes to offset 9 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | NCH | Monitored inputs, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write offset |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | AW | Read offset |
| rd_data | output | 8 | Read data byte (combinational) |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach is an enabled edge that lands in the same cycle as a clear write. Both events must be lined up at one clock edge, and the outcome differs depending on whether the edge flag was already set. The bench drives this directly, both with the flag clear and with the flag set. Its random phase mixes sparse input toggles with frequent writes to random offsets, so clear writes often coincide with edges. A cycle model built from the requirements checks the status byte and `irq` after every edge.

// File: rtl/edge_event_irq.sv
module edge_event_irq #(
  parameter int NBYTES = 3,
  parameter int AW = 4,
  localparam int NCH = 8 * NBYTES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] din,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [7:0]     rd_data,
  output logic           irq
);
  localparam int RISE_BASE = 0;
  localparam int FALL_BASE = 4;
  localparam int CTL_ADDR  = 8;
  localparam int STAT_ADDR = 9;
  localparam int CLR_ADDR  = 10;

  logic [NCH-1:0] din_q, rise_en, fall_en;
  logic [4:0] ctl;
  logic edge_flag, ovf_flag;

  wire clr_wr  = wr_en && (wr_addr == AW'(CLR_ADDR));
  wire clr_edg = clr_wr && wr_data[3];
  wire clr_ovf = clr_wr && wr_data[2];

  wire [NCH-1:0] rise_hit = din & ~din_q & rise_en & {NCH{ctl[3]}};
  wire [NCH-1:0] fall_hit = ~din & din_q & fall_en & {NCH{ctl[4]}};
  wire hit = (|rise_hit) | (|fall_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q   <= '0;
      rise_en <= '0;
      fall_en <= '0;
      ctl     <= '0;
    end else begin
      din_q <= din;
      for (int b = 0; b < NBYTES; b++) begin
        if (wr_en && wr_addr == AW'(RISE_BASE + b)) rise_en[8*b +: 8] <= wr_data;
        if (wr_en && wr_addr == AW'(FALL_BASE + b)) fall_en[8*b +: 8] <= wr_data;
      end
      if (wr_en && wr_addr == AW'(CTL_ADDR)) ctl <= wr_data[4:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_flag <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      if (hit)          edge_flag <= 1'b1;
      else if (clr_edg) edge_flag <= 1'b0;
      if (hit && edge_flag) ovf_flag <= 1'b1;
      else if (clr_ovf)     ovf_flag <= 1'b0;
    end
  end

  assign irq = ctl[2] & ((edge_flag & ctl[0]) | (ovf_flag & ctl[1]));

  always_comb begin
    rd_data = 8'h00;
    for (int b = 0; b < NBYTES; b++) begin
      if (rd_addr == AW'(RISE_BASE + b)) rd_data = rise_en[8*b +: 8];
      if (rd_addr == AW'(FALL_BASE + b)) rd_data = fall_en[8*b +: 8];
    end
    if (rd_addr == AW'(CTL_ADDR))  rd_data = {3'b000, ctl};
    if (rd_addr == AW'(STAT_ADDR)) rd_data = {5'b00000, irq, ovf_flag, edge_flag};
  end

  // R8: an enabled change always leaves the edge flag set
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> edge_flag);
  // R6: overflow only rises on top of an existing edge flag
  a_r6_ovf_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(edge_flag));
  // R6: the edge flag is sticky until a clear
  a_r6_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag && !clr_edg) |=> edge_flag);
  // R7: a clear with no concurrent change empties the edge flag
  a_r7_clear_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edg && !hit) |=> !edge_flag);
  // R9: no interrupt without master enable
  a_r9_irq_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl[2]);
  // R5: a stable input bank never raises the edge flag
  a_r5_quiet_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_flag && din == din_q) |=> !edge_flag);
endmodule

// File: tb/test_edge_event_irq.sv
module test_edge_event_irq;
  localparam int NCH = 24;
  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] din = '0;
  logic wr_en = 0;
  logic [3:0] wr_addr = '0, rd_addr = 4'd9;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [NCH-1:0] m_rise = '0, m_fall = '0, m_prev = '0;
  logic [4:0] m_ctl = '0;
  logic m_edge = 0, m_ovf = 0;

  edge_event_irq i_edge_event_irq (.clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  always #5 clk = ~clk;

  function automatic logic exp_irq();
    return m_ctl[2] & ((m_edge & m_ctl[0]) | (m_ovf & m_ctl[1]));
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a; #1;
    chk(rd_data, exp, tag);
    rd_addr = 4'd9; #1;
  endtask

  task automatic cyc(input logic [NCH-1:0] d, input logic we, input logic [3:0] a,
                     input logic [7:0] wd, input string tag);
    logic hit, ne, no;
    @(negedge clk);
    din = d; wr_en = we; wr_addr = a; wr_data = wd;
    hit = (|(d & ~m_prev & m_rise & {NCH{m_ctl[3]}})) | (|(~d & m_prev & m_fall & {NCH{m_ctl[4]}}));
    ne = hit | (m_edge & ~(we && a == 4'd10 && wd[3]));
    no = (hit & m_edge) | (m_ovf & ~(we && a == 4'd10 && wd[2]));
    m_edge = ne; m_ovf = no; m_prev = d;
    if (we) begin
      for (int b = 0; b < 3; b++) begin
        if (a == 4'(b))     m_rise[8*b +: 8] = wd;
        if (a == 4'(4 + b)) m_fall[8*b +: 8] = wd;
      end
      if (a == 4'd8) m_ctl = wd[4:0];
    end
    @(posedge clk); #1;
    wr_en = 0;
    chk(rd_data, {5'b0, exp_irq(), m_ovf, m_edge}, tag);
    chk({7'b0, irq}, {7'b0, exp_irq()}, {tag, " irq"});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NCH-1:0] d;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    rd(4'd0, 8'h00, "R1 rise0"); rd(4'd6, 8'h00, "R1 fall2");
    rd(4'd8, 8'h00, "R1 ctl"); rd(4'd9, 8'h00, "R1 status");
    chk({7'b0, irq}, 8'h00, "R1 irq");
    @(negedge clk); rst_n = 1;
    // R2 masks
    cyc(24'h0, 1, 4'd0, 8'h0F, "R2 w"); cyc(24'h0, 1, 4'd1, 8'h00, "R2 w");
    cyc(24'h0, 1, 4'd2, 8'h80, "R2 w"); cyc(24'h0, 1, 4'd4, 8'hF0, "R2 w");
    cyc(24'h0, 1, 4'd5, 8'h00, "R2 w"); cyc(24'h0, 1, 4'd6, 8'h01, "R2 w");
    rd(4'd0, 8'h0F, "R2 rise0"); rd(4'd2, 8'h80, "R2 rise2");
    rd(4'd4, 8'hF0, "R2 fall0"); rd(4'd6, 8'h01, "R2 fall2");
    // R10 control width, status write ignored
    cyc(24'h0, 1, 4'd8, 8'hFF, "R10 ctl");
    rd(4'd8, 8'h1F, "R10 ctl readback");
    cyc(24'h0, 1, 4'd9, 8'hFF, "R10 status write ignored");
    // R5 unmasked channel
    cyc(24'h000100, 0, 0, 0, "R5 unmasked rise");
    cyc(24'h000000, 0, 0, 0, "R5 unmasked fall");
    // R3 rising edge, R9 irq
    cyc(24'h000001, 0, 0, 0, "R3 rise sets edge R9");
    // R6 overflow
    cyc(24'h000003, 0, 0, 0, "R6 overflow");
    cyc(24'h000003, 0, 0, 0, "R6 sticky");
    // R7 clears
    cyc(24'h000003, 1, 4'd10, 8'h08, "R7 clear edge only");
    cyc(24'h000003, 1, 4'd10, 8'h03, "R7 other bits no effect");
    cyc(24'h000003, 1, 4'd10, 8'h04, "R7 clear overflow");
    // R4 falling edge on ch4 (rising ignored since rise mask off)
    cyc(24'h000013, 0, 0, 0, "R5 rise on fall-only channel");
    cyc(24'h000003, 0, 0, 0, "R4 fall sets edge");
    // R8 set wins over clear, with flag set and not
    cyc(24'h000023, 1, 4'd10, 8'h0C, "R8 prep");
    cyc(24'h000003, 1, 4'd10, 8'h0C, "R8 fall with clear, flag clear");
    cyc(24'h000002, 1, 4'd10, 8'h0C, "R8 fall ch0 none, clear");
    cyc(24'h000003, 1, 4'd10, 8'h0C, "R8 rise with clear");
    cyc(24'h000002, 0, 0, 0, "R8 hold");
    cyc(24'h000003, 1, 4'd10, 8'h0C, "R8 rise with clear, flag set");
    // R9 master and source gating
    cyc(24'h000003, 1, 4'd8, 8'h1B, "R9 master off");
    cyc(24'h000003, 1, 4'd8, 8'h1E, "R9 edge src off");
    cyc(24'h000002, 0, 0, 0, "R9 flag set");
    cyc(24'h000003, 0, 0, 0, "R9 overflow src");
    cyc(24'h000003, 1, 4'd10, 8'h0C, "R9 cleared");
    // R5 polarity gate off
    cyc(24'h000003, 1, 4'd8, 8'h17, "R5 gate");
    cyc(24'h000002, 0, 0, 0, "R5 ch0 fall no mask");
    cyc(24'h000003, 0, 0, 0, "R5 rise gate off");
    // random phase
    d = 24'h000003;
    for (int i = 0; i < 3000; i++) begin
      logic we;
      d = d ^ ($urandom() & $urandom() & $urandom());
      we = ($urandom() % 5) == 0;
      cyc(d, we, 4'($urandom() % 11), 8'($urandom()), "R3/R4/R6/R7/R8/R9 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule